// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a microprogrammed processor. It holds the control address register (CAR). The CAR drives the read address of a 256-word control store. The store returns a 32-bit control word for that address within the same cycle, and the sequencer captures that word in a control buffer register. The registered copy drives the datapath control vector. The top 3 bits of the vector are also presented separately as the ALU operation.

Each control word carries a 2-bit encoded jump condition and an 8-bit next-address field. All the other bits are plain horizontal control lines. The jump condition selects the next CAR value from four sources:
- the incremented CAR;
- the next-address field;
- a routine base derived from the instruction opcode;
- the next-address field gated by a status flag.

Routine bases are spaced ten words apart, so opcode k starts at microaddress (k+1)*10. An opcode whose base would not fit in the address space is sent to the halt routine's base.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, `cs_addr` and `ctl_word` are 0. This takes effect without waiting for a clock edge.
- R2: When the current control word has jump condition 2'b00 (bits 9..8), the next `cs_addr` is the current `cs_addr` plus 1, wrapping from 8'hFF to 8'h00.
- R3: When the jump condition is 2'b01, the next `cs_addr` is the next-address field (bits 7..0) of the current word.
- R4: When the jump condition is 2'b11, the next `cs_addr` is the next-address field if `flag` is 0. If `flag` is 1, it is `cs_addr` plus 1. `flag` has no effect under the other three conditions.
- R5: When the jump condition is 2'b10 and `opcode` is 0 to 24, the next `cs_addr` is (`opcode`+1)*10. Examples: 8'h00 goes to 8'h0A, 8'h01 to 8'h14, 8'h07 to 8'h50, 8'h0C to 8'h82, and 8'h18 to 8'hFA. The next-address field and `flag` are ignored.
- R6: When the jump condition is 2'b10 and `opcode` is 25 or above, the next `cs_addr` is the halt routine base 8'h82, the base of opcode 8'h0C.
- R7: `ctl_word` equals bits 31..10 of the control word that was read at the previous clock edge. `alu_op` equals bits 31..29 of that same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag | input | 1 | Status flag tested by the conditional jump |
| opcode | input | 8 | Opcode field of the instruction register |
| cword | input | 32 | Control word read from the store at `cs_addr` |
| cs_addr | output | 8 | Control address register, drives the control store address |
| ctl_word | output | 22 | Registered control bits 31..10 of the last word read |
| alu_op | output | 3 | Registered ALU operation, bits 31..29 of the last word read |

## Verification
The assertions rely on three assumptions about the inputs:
- `cword` is a pure combinational function of `cs_addr`, so the word the sequencer decodes is the one at the address it issued.
- `flag` holds a known value across each rising edge.
- `opcode` holds a known value across each rising edge.

The bench models the control store as a combinational array indexed by `cs_addr`. It changes `flag`, `opcode` and `rst_n` only at falling edges, so these inputs are always settled when the next rising edge arrives.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Encoded next-address selection carried in each control word
  typedef enum logic [1:0] {
    JC_STEP = 2'b00,  // sequential: CAR + 1
    JC_GOTO = 2'b01,  // unconditional branch to next-address field
    JC_MAP  = 2'b10,  // dispatch on instruction opcode
    JC_IFZ  = 2'b11   // branch when flag is clear, else step
  } jcond_e;

  localparam int unsigned JC_W = 2;

endpackage

// File: rtl/useq_opmap.sv
module useq_opmap #(
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned AW      = 8,
  parameter int unsigned SPACING = 10,
  parameter int unsigned HALT_OP = 12
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [AW-1:0]    map_base
);

  localparam int unsigned NUM_OPC   = 1 << OPC_W;
  localparam int unsigned LAST_OP   = ((1 << AW) - 1) / SPACING - 1;
  localparam logic [AW-1:0] HALT_BASE = AW'((HALT_OP + 1) * SPACING);

  logic [AW-1:0] base_tbl [NUM_OPC];

  // Constant base per opcode; out-of-reach opcodes fall to the halt routine
  for (genvar g = 0; g < NUM_OPC; g++) begin : g_base
    if (g <= LAST_OP) begin : g_fit
      assign base_tbl[g] = AW'((g + 1) * SPACING);
    end else begin : g_halt
      assign base_tbl[g] = HALT_BASE;
    end
  end

  assign map_base = base_tbl[opcode];

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0]   car_q,
  input  logic [JC_W-1:0] jcond,
  input  logic [AW-1:0]   nxt_field,
  input  logic [AW-1:0]   map_base,
  input  logic            flag,
  output logic [AW-1:0]   car_d
);

  logic [AW-1:0] car_inc;

  assign car_inc = car_q + AW'(1);

  always_comb begin
    unique case (jcond_e'(jcond))
      JC_STEP: car_d = car_inc;
      JC_GOTO: car_d = nxt_field;
      JC_MAP:  car_d = map_base;
      JC_IFZ:  car_d = flag ? car_inc : nxt_field;
      default: car_d = car_inc;
    endcase
  end

endmodule

// File: rtl/useq_cbr.sv
module useq_cbr #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned CWORD_W = 32,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned ALU_W   = 3,
  parameter int unsigned SPACING = 10,
  parameter int unsigned HALT_OP = 12,
  parameter int unsigned CTL_W   = CWORD_W - JC_W - AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flag,
  input  logic [OPC_W-1:0]   opcode,
  input  logic [CWORD_W-1:0] cword,
  output logic [AW-1:0]      cs_addr,
  output logic [CTL_W-1:0]   ctl_word,
  output logic [ALU_W-1:0]   alu_op
);

  localparam int unsigned JC_LSB  = AW;
  localparam int unsigned CTL_LSB = AW + JC_W;

  logic [AW-1:0]    car_q;
  logic [AW-1:0]    car_d;
  logic [AW-1:0]    map_base;
  logic [JC_W-1:0]  jcond;
  logic [AW-1:0]    nxt_field;
  logic [CTL_W-1:0] ctl_field;

  assign jcond     = cword[JC_LSB +: JC_W];
  assign nxt_field = cword[AW-1:0];
  assign ctl_field = cword[CTL_LSB +: CTL_W];

  useq_opmap #(
    .OPC_W  (OPC_W),
    .AW     (AW),
    .SPACING(SPACING),
    .HALT_OP(HALT_OP)
  ) u_opmap (
    .opcode  (opcode),
    .map_base(map_base)
  );

  useq_nextaddr #(
    .AW(AW)
  ) u_next (
    .car_q    (car_q),
    .jcond    (jcond),
    .nxt_field(nxt_field),
    .map_base (map_base),
    .flag     (flag),
    .car_d    (car_d)
  );

  // Control address register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) car_q <= '0;
    else        car_q <= car_d;
  end

  // Control buffer register: loads every cycle
  useq_cbr #(
    .W(CTL_W)
  ) u_cbr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(1'b1),
    .d      (ctl_field),
    .q      (ctl_word)
  );

  assign cs_addr = car_q;
  assign alu_op  = ctl_word[CTL_W-1 -: ALU_W];

endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int unsigned AW      = 8,
  parameter int unsigned CWORD_W = 32,
  parameter int unsigned OPC_W   = 8,
  parameter int unsigned ALU_W   = 3,
  parameter int unsigned SPACING = 10,
  parameter int unsigned HALT_OP = 12,
  parameter int unsigned CTL_W   = 22
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flag,
  input logic [OPC_W-1:0]   opcode,
  input logic [CWORD_W-1:0] cword,
  input logic [AW-1:0]      cs_addr,
  input logic [CTL_W-1:0]   ctl_word,
  input logic [ALU_W-1:0]   alu_op
);

  localparam int unsigned LAST_OP = ((1 << AW) - 1) / SPACING - 1;
  localparam logic [AW-1:0] HALT_BASE = AW'((HALT_OP + 1) * SPACING);

  logic [1:0] jc;
  assign jc = cword[AW+1:AW];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (cs_addr == '0 && ctl_word == '0));

  // R2
  seq_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jc == 2'b00 |=> cs_addr == AW'($past(cs_addr) + 1'b1));

  // R3
  goto_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jc == 2'b01 |=> cs_addr == $past(cword[AW-1:0]));

  // R4
  ifz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jc == 2'b11 && !flag) |=> cs_addr == $past(cword[AW-1:0]));

  // R4
  ifz_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jc == 2'b11 && flag) |=> cs_addr == AW'($past(cs_addr) + 1'b1));

  // R5
  map_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jc == 2'b10 && int'(opcode) <= LAST_OP)
      |=> cs_addr == AW'((int'($past(opcode)) + 1) * SPACING));

  // R6
  map_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jc == 2'b10 && int'(opcode) > LAST_OP) |=> cs_addr == HALT_BASE);

  // R7
  cbr_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ctl_word == $past(cword[CWORD_W-1 -: CTL_W]));

  // R7
  aluop_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> alu_op == $past(cword[CWORD_W-1 -: ALU_W]));

endmodule

bind useq_ctrl useq_ctrl_chk #(
  .AW     (AW),
  .CWORD_W(CWORD_W),
  .OPC_W  (OPC_W),
  .ALU_W  (ALU_W),
  .SPACING(SPACING),
  .HALT_OP(HALT_OP),
  .CTL_W  (CTL_W)
) u_useq_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .flag    (flag),
  .opcode  (opcode),
  .cword   (cword),
  .cs_addr (cs_addr),
  .ctl_word(ctl_word),
  .alu_op  (alu_op)
);

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        flag;
  logic [7:0]  opcode;
  logic [31:0] cword;
  logic [7:0]  cs_addr;
  logic [21:0] ctl_word;
  logic [2:0]  alu_op;

  logic [31:0] rom [256];
  int n_chk;
  int n_fail;
  bit done;

  useq_ctrl uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .flag    (flag),
    .opcode  (opcode),
    .cword   (cword),
    .cs_addr (cs_addr),
    .ctl_word(ctl_word),
    .alu_op  (alu_op)
  );

  assign cword = rom[cs_addr];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [16:0] C8 = 17'h00100;
  localparam logic [16:0] C4 = 17'h00010;
  localparam logic [16:0] C3 = 17'h00008;

  // {opcode, flag, routine base, address after base, edges from base back to 0}
  localparam logic [39:0] VECS [12] = '{
    {8'h00, 8'h00, 8'h0A, 8'h0B, 8'd6},
    {8'h01, 8'h01, 8'h14, 8'h15, 8'd4},
    {8'h02, 8'h00, 8'h1E, 8'h1F, 8'd6},
    {8'h03, 8'h01, 8'h28, 8'h29, 8'd6},
    {8'h04, 8'h00, 8'h32, 8'h33, 8'd3},
    {8'h05, 8'h01, 8'h3C, 8'h3D, 8'd3},
    {8'h06, 8'h00, 8'h46, 8'h47, 8'd6},
    {8'h07, 8'h01, 8'h50, 8'h51, 8'd6},
    {8'h0A, 8'h00, 8'h6E, 8'h78, 8'd2},
    {8'h0A, 8'h01, 8'h6E, 8'h6F, 8'd2},
    {8'h18, 8'h01, 8'hFA, 8'h00, 8'd1},
    {8'h17, 8'h00, 8'hF0, 8'hFF, 8'd2}
  };

  function automatic logic [31:0] mw(input logic [2:0] op, input logic [16:0] c,
                                     input logic [1:0] jc, input logic [7:0] a);
    return {op, 2'b00, c, jc, a};
  endfunction

  task automatic routine(input logic [7:0] b, input int n, input logic [2:0] op);
    for (int k = 0; k < n - 1; k++)
      rom[8'(b + k)] = mw(op, 17'(1 << k) | 17'h10000, 2'b00, 8'h00);
    rom[8'(b + n - 1)] = mw(3'd0, C8, 2'b01, 8'h00);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; flag = 1'b0; opcode = 8'h00;
    for (int a = 0; a < 256; a++) rom[a] = 32'h0;
    // fetch words 00..03
    rom[8'h00] = mw(3'd0, C8, 2'b00, 8'h00);
    rom[8'h01] = mw(3'd0, 17'h00201, 2'b00, 8'h00);
    rom[8'h02] = mw(3'd0, 17'h00020, 2'b00, 8'h00);
    rom[8'h03] = mw(3'd2, 17'h00000, 2'b10, 8'h55);
    routine(8'h0A, 6, 3'd0);
    routine(8'h14, 4, 3'd1);
    routine(8'h1E, 6, 3'd2);
    routine(8'h28, 6, 3'd3);
    routine(8'h32, 3, 3'd7);
    routine(8'h3C, 3, 3'd6);
    routine(8'h46, 6, 3'd3);
    routine(8'h50, 6, 3'd4);
    routine(8'hFA, 1, 3'd0);
    rom[8'h6E] = mw(3'd5, C3, 2'b11, 8'h78);
    rom[8'h6F] = mw(3'd0, C8, 2'b01, 8'h00);
    rom[8'h78] = mw(3'd0, C4, 2'b01, 8'h00);
    rom[8'hF0] = mw(3'd6, C3, 2'b01, 8'hFF);
    rom[8'hFF] = mw(3'd7, C4, 2'b00, 8'h00);
    rom[8'h82] = mw(3'd0, 17'h0, 2'b01, 8'h82);

    step(2);
    chk("R1 reset addr", 32'(cs_addr), 32'h0);
    chk("R1 reset ctl", 32'(ctl_word), 32'h0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      logic [7:0] op, bs, sa, ln;
      string t2, t3;
      op = VECS[i][39:32]; bs = VECS[i][23:16]; sa = VECS[i][15:8]; ln = VECS[i][7:0];
      t2 = (op == 8'h0A) ? "R4 cond jump" : (op >= 8'h17) ? "R3 goto" : "R2 step";
      t3 = (op == 8'h17) ? "R2 wrap" : "R3 return";
      opcode = op; flag = VECS[i][24];
      chk("R2 start", 32'(cs_addr), 32'h0);
      step(4);
      chk("R5 dispatch", 32'(cs_addr), 32'(bs));
      chk("R7 ctl delay", 32'(ctl_word), 32'(rom[8'h03][31:10]));
      step(1);
      chk(t2, 32'(cs_addr), 32'(sa));
      chk("R7 alu_op", 32'(alu_op), 32'(rom[bs][31:29]));
      step(int'(ln) - 1);
      chk(t3, 32'(cs_addr), 32'h0);
    end

    // halt routine: spins on itself, flag ignored
    opcode = 8'h0C; flag = 1'b0;
    step(4);
    chk("R5 halt base", 32'(cs_addr), 32'h82);
    step(1);
    chk("R3 halt self", 32'(cs_addr), 32'h82);
    chk("R7 halt ctl", 32'(ctl_word), 32'h0);
    flag = 1'b1;
    step(3);
    chk("R4 flag ignored", 32'(cs_addr), 32'h82);

    // asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async addr", 32'(cs_addr), 32'h0);
    chk("R1 async ctl", 32'(ctl_word), 32'h0);
    @(negedge clk);
    chk("R1 held", 32'(cs_addr), 32'h0);
    rst_n = 1'b1;
    opcode = 8'hFF;
    step(4);
    chk("R6 opcode FF", 32'(cs_addr), 32'h82);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    opcode = 8'h19;
    step(4);
    chk("R6 opcode 25", 32'(cs_addr), 32'h82);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule